// File: doc/BRIEF.md
# Protocol Discovery Responder

This block sits behind a config-space mailbox and answers protocol discovery requests. After a start pulse it reads one request object, a dword at a time, from the mailbox write buffer. It checks the two header dwords and reads the queried index from the first payload dword. It then looks that index up in a fixed table of supported (vendor ID, protocol type) pairs. A valid query produces a three-dword response, pushed into the mailbox read buffer, followed by a one-cycle `done` pulse. Any request the responder cannot answer ends with a one-cycle `error` pulse and no response.

Host software lists every supported protocol by chaining queries. It starts at index 0. Each response carries one table entry and the index of the entry after it. A returned next index of 0 means the entry just reported is the last one. Entry 0 is always the discovery protocol itself, with vendor ID 0x0001 and type 0x00. The remaining entries come from a parameter, with at most eight entries in total.

Top module: `disc_responder`

## Requirements
- R1: While reset is high and in the first cycle after it, `req_pop`, `rsp_push`, `done` and `error` are all low.
- R2: In request header dword 1, bits 15:0 are the vendor ID and bits 23:16 are the object type. In header dword 2, bits 17:0 are the object length in dwords, and the two header dwords are included in that count.
- R3: A discovery request is vendor 0x0001, type 0x00, length of at least 3, and an index inside the table. It is answered with three pushes in consecutive cycles: 0x00000001, then 0x00000003, then the entry dword. A `done` pulse follows in the cycle after the third push.
- R4: Table entry 0 always reports the discovery protocol: vendor 0x0001, type 0x00.
- R5: The entry dword carries the vendor ID in bits 15:0, the protocol type in bits 23:16 and the next index in bits 31:24. The next index is the queried index plus one, or 0 for the last entry. Following the chain from index 0 visits every entry exactly once.
- R6: The queried index is taken from bits 7:0 of the first payload dword. Bits 31:8 of that dword have no effect on the response.
- R7: A queried index equal to or above the table size gives an `error` pulse and no response dwords.
- R8: A length field below 3 gives an `error` pulse straight after header dword 2. No further request dwords are consumed.
- R9: A vendor/type pair other than (0x0001, 0x00), with a length of 3 or more, has all of its declared dwords consumed. It then gives an `error` pulse and no response dwords.
- R10: A longer discovery object has every declared dword consumed, and its extra payload dwords are ignored.
- R11: `req_pop` is raised only while `req_avail` is high. When the buffer runs empty mid-object, the responder waits without losing its place.
- R12: A start pulse that arrives while a request is being handled is ignored.
- R13: Each accepted start ends in exactly one single-cycle pulse of either `done` or `error`, never both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin handling the object in the write buffer |
| req_avail | input | 1 | Write buffer holds a dword (first-word fall-through) |
| req_data | input | 32 | Dword at the head of the write buffer |
| req_pop | output | 1 | Consume the head dword this cycle |
| rsp_push | output | 1 | Push `rsp_data` into the read buffer |
| rsp_data | output | 32 | Response dword |
| done | output | 1 | One-cycle pulse: response complete |
| error | output | 1 | One-cycle pulse: request rejected |

## Verification
The bench aims at the edges of the index range. It queries the last entry, which must return next index 0, and the index equal to the table size, which must be rejected. A design with an off-by-one here would either never end the chain or report an empty slot as a protocol. It also sends length fields of 0, 2 and 5, plus a foreign vendor/type pair, and checks how many dwords stay in the buffer afterwards. A responder that under- or over-consumes would leave the mailbox misaligned for the next object. The bench further checks stalls in the buffer feed, a second start pulse during a request, and junk in the upper bits of the index dword. These catch a responder that drops or repeats dwords, restarts mid-object, or decodes a wide index.

// File: rtl/disc_pkg.sv
package disc_pkg;
    localparam logic [15:0] STD_VID   = 16'h0001;
    localparam logic [7:0]  DISC_TYPE = 8'h00;
    localparam int          LEN_W     = 18;
    localparam logic [LEN_W-1:0] DISC_LEN = 18'd3;
    localparam int          MAX_ENT   = 8;
    localparam int          IDX_W     = $clog2(MAX_ENT);

    typedef struct packed {
        logic [7:0]  proto;
        logic [15:0] vid;
    } prot_ent_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_HDR1, ST_HDR2, ST_BODY, ST_EVAL, ST_RSP, ST_DONE, ST_FAIL
    } rsp_state_t;

    typedef enum logic [1:0] {SEL_HDR1, SEL_HDR2, SEL_ENTRY} rsp_sel_t;

    function automatic logic [31:0] mk_hdr1(input logic [15:0] vid, input logic [7:0] typ);
        return {8'h00, typ, vid};
    endfunction

    function automatic logic [31:0] mk_hdr2(input logic [LEN_W-1:0] len);
        return {{(32-LEN_W){1'b0}}, len};
    endfunction

    function automatic logic [31:0] mk_entry(input prot_ent_t e, input logic [7:0] nxt);
        return {nxt, e.proto, e.vid};
    endfunction
endpackage

// File: rtl/disc_table.sv
module disc_table
    import disc_pkg::*;
#(
    parameter int N_ENT = 4,
    parameter logic [MAX_ENT-1:0][23:0] ENT_TABLE = '0
) (
    input  logic [7:0] idx,
    output logic       hit,
    output prot_ent_t  ent,
    output logic [7:0] next_idx
);
    prot_ent_t slots [MAX_ENT];

    for (genvar g = 0; g < MAX_ENT; g++) begin : g_slot
        if (g == 0) begin : g_self
            assign slots[g] = '{proto: DISC_TYPE, vid: STD_VID};
        end else if (g < N_ENT) begin : g_used
            assign slots[g] = prot_ent_t'(ENT_TABLE[g]);
        end else begin : g_empty
            assign slots[g] = '0;
        end
    end

    logic [8:0] inc;

    always_comb begin
        inc      = {1'b0, idx} + 9'd1;
        hit      = int'(idx) < N_ENT;
        ent      = slots[idx[IDX_W-1:0]];
        next_idx = (int'(inc) < N_ENT) ? inc[7:0] : 8'd0;
    end
endmodule

// File: rtl/disc_fmt.sv
module disc_fmt
    import disc_pkg::*;
(
    input  rsp_sel_t    sel,
    input  prot_ent_t   ent,
    input  logic [7:0]  next_idx,
    output logic [31:0] data
);
    always_comb begin
        case (sel)
            SEL_HDR1: data = mk_hdr1(STD_VID, DISC_TYPE);
            SEL_HDR2: data = mk_hdr2(DISC_LEN);
            default:  data = mk_entry(ent, next_idx);
        endcase
    end
endmodule

// File: rtl/disc_ctrl.sv
module disc_ctrl
    import disc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        req_avail,
    input  logic [31:0] req_data,
    input  logic        hit,
    output logic [7:0]  idx,
    output logic        req_pop,
    output logic        rsp_push,
    output rsp_sel_t    sel,
    output logic        done,
    output logic        error
);
    rsp_state_t       state;
    logic [15:0]      hv;
    logic [7:0]       ht;
    logic [LEN_W-1:0] remain;
    logic             first;
    logic [1:0]       cnt;
    logic [LEN_W-1:0] len_in;
    logic             pair_ok;
    logic             unused_hi;

    assign unused_hi = ^req_data[31:24];
    assign len_in    = req_data[LEN_W-1:0];
    assign pair_ok   = (hv == STD_VID) && (ht == DISC_TYPE);

    always_comb begin
        req_pop  = req_avail && (state inside {ST_HDR1, ST_HDR2, ST_BODY});
        rsp_push = (state == ST_RSP);
        done     = (state == ST_DONE);
        error    = (state == ST_FAIL);
        case (cnt)
            2'd0:    sel = SEL_HDR1;
            2'd1:    sel = SEL_HDR2;
            default: sel = SEL_ENTRY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            hv     <= '0;
            ht     <= '0;
            remain <= '0;
            first  <= 1'b0;
            idx    <= '0;
            cnt    <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) state <= ST_HDR1;
                ST_HDR1: if (req_avail) begin
                    hv    <= req_data[15:0];
                    ht    <= req_data[23:16];
                    state <= ST_HDR2;
                end
                ST_HDR2: if (req_avail) begin
                    if (len_in < DISC_LEN) begin
                        state <= ST_FAIL;
                    end else begin
                        remain <= len_in - 18'd2;
                        first  <= 1'b1;
                        state  <= ST_BODY;
                    end
                end
                ST_BODY: if (req_avail) begin
                    if (first) idx <= req_data[7:0];
                    first  <= 1'b0;
                    remain <= remain - 18'd1;
                    if (remain == 18'd1) state <= ST_EVAL;
                end
                ST_EVAL: begin
                    cnt   <= '0;
                    state <= (pair_ok && hit) ? ST_RSP : ST_FAIL;
                end
                ST_RSP: begin
                    cnt <= cnt + 2'd1;
                    if (cnt == 2'd2) state <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/disc_responder.sv
module disc_responder
    import disc_pkg::*;
#(
    parameter int N_ENT = 4,
    parameter logic [MAX_ENT-1:0][23:0] ENT_TABLE = {24'h0, 24'h0, 24'h0, 24'h0,
                                                     24'h07ABCD, 24'h020001, 24'h010001, 24'h0}
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        req_avail,
    input  logic [31:0] req_data,
    output logic        req_pop,
    output logic        rsp_push,
    output logic [31:0] rsp_data,
    output logic        done,
    output logic        error
);
    logic [7:0] idx;
    logic       hit;
    prot_ent_t  ent;
    logic [7:0] next_idx;
    rsp_sel_t   sel;

    disc_ctrl u_ctrl (
        .clk(clk), .rst(rst), .start(start),
        .req_avail(req_avail), .req_data(req_data), .hit(hit),
        .idx(idx), .req_pop(req_pop), .rsp_push(rsp_push),
        .sel(sel), .done(done), .error(error)
    );

    disc_table #(.N_ENT(N_ENT), .ENT_TABLE(ENT_TABLE)) u_table (
        .idx(idx), .hit(hit), .ent(ent), .next_idx(next_idx)
    );

    disc_fmt u_fmt (
        .sel(sel), .ent(ent), .next_idx(next_idx), .data(rsp_data)
    );
endmodule

// File: rtl/disc_responder_chk.sv
module disc_responder_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_avail,
    input logic        req_pop,
    input logic        rsp_push,
    input logic [31:0] rsp_data,
    input logic        done,
    input logic        error
);
    AST_POP_NEEDS_AVAIL: assert property (@(posedge clk) disable iff (rst)
        req_pop |-> req_avail); // R11
    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(done && error)); // R13
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R13
    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        error |=> !error); // R13
    AST_DONE_AFTER_RSP: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(rsp_push)); // R3
    AST_RSP_FIRST_HDR: assert property (@(posedge clk) disable iff (rst)
        (rsp_push && !$past(rsp_push)) |-> rsp_data == 32'h0000_0001); // R3
    AST_RSP_LEN_FIELD: assert property (@(posedge clk) disable iff (rst)
        (rsp_push && $past(rsp_push) && $past(rsp_data) == 32'h0000_0001)
            |-> rsp_data == 32'h0000_0003); // R3
    AST_ERR_NO_RSP: assert property (@(posedge clk) disable iff (rst)
        error |-> !$past(rsp_push)); // R7
    AST_END_NO_POP: assert property (@(posedge clk) disable iff (rst)
        (done || error) |-> !req_pop); // R12
endmodule

bind disc_responder disc_responder_chk u_chk (.*);

// File: tb/tb_disc_responder.sv
`timescale 1ns/1ps
module tb_disc_responder;
    typedef logic [31:0] dq_t[$];

    localparam int N = 4;
    localparam logic [7:0][23:0] TBL = {24'h0, 24'h0, 24'h0, 24'h0,
                                        24'h07ABCD, 24'h020001, 24'h010001, 24'h0};
    localparam logic [31:0] SENT = 32'hDEAD_BEEF;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        req_avail;
    logic [31:0] req_data;
    logic        req_pop;
    logic        rsp_push;
    logic [31:0] rsp_data;
    logic        done;
    logic        error;

    always #2.5 clk = ~clk;

    disc_responder #(.N_ENT(N), .ENT_TABLE(TBL)) dut (
        .clk(clk), .rst(rst), .start(start),
        .req_avail(req_avail), .req_data(req_data), .req_pop(req_pop),
        .rsp_push(rsp_push), .rsp_data(rsp_data), .done(done), .error(error)
    );

    logic [31:0] q[$];
    logic [31:0] got[$];
    int          got_cyc[$];
    bit          pop_seen;
    bit          stall_en;
    int          cyc;
    int          n_done, n_err;
    int          checks, errors;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_entry(input int idx);
        logic [23:0] e;
        int          nxt;
        e   = (idx == 0) ? 24'h00_0001 : TBL[idx];
        nxt = (idx + 1 < N) ? idx + 1 : 0;
        return {nxt[7:0], e};
    endfunction

    // buffer model: head dword removed after the edge where it was popped
    always @(posedge clk) begin
        #1;
        if (pop_seen && q.size() > 0) void'(q.pop_front());
        pop_seen  = 1'b0;
        req_avail = (q.size() > 0) && !(stall_en && (cyc % 3 != 0));
        req_data  = (q.size() > 0) ? q[0] : 32'h0;
    end

    // per-clock monitor
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (req_pop) pop_seen = 1'b1;
            chk(!(req_pop && !req_avail), "R11", "pop without data", {31'b0, req_pop}, 32'h0);
            chk(!(done && error), "R13", "done with error", {31'b0, done}, 32'h0);
            if (rsp_push) begin
                got.push_back(rsp_data);
                got_cyc.push_back(cyc);
            end
            if (done) n_done++;
            if (error) n_err++;
        end
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic pulse_start();
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
    endtask

    task automatic run(input dq_t obj, input bit exp_ok, input logic [31:0] exp3,
                       input int exp_left, input string req, input bit dbl);
        int t;
        @(negedge clk);
        got.delete(); got_cyc.delete();
        n_done = 0; n_err = 0;
        q = obj;
        q.push_back(SENT);
        pulse_start();
        if (dbl) begin
            repeat (2) @(posedge clk);
            #1 start = 1'b1;
            @(posedge clk); #1 start = 1'b0;
        end
        t = 0;
        while (n_done + n_err == 0 && t < 400) begin
            @(negedge clk);
            t++;
        end
        repeat (6) @(negedge clk);
        if (exp_ok) begin
            chk(n_done == 1 && n_err == 0, req, "done count", n_done, 1);
            chk(got.size() == 3, req, "response size", got.size(), 3);
            if (got.size() == 3) begin
                chk(got[0] == 32'h1, req, "rsp hdr1", got[0], 32'h1);
                chk(got[1] == 32'h3, req, "rsp hdr2", got[1], 32'h3);
                chk(got[2] == exp3, req, "rsp entry", got[2], exp3);
                chk(got_cyc[2] - got_cyc[0] == 2, req, "back-to-back pushes",
                    got_cyc[2] - got_cyc[0], 2);
            end
        end else begin
            chk(n_err == 1 && n_done == 0, req, "error count", n_err, 1);
            chk(got.size() == 0, req, "no response", got.size(), 0);
        end
        chk(q.size() == exp_left, req, "dwords left", q.size(), exp_left);
        if (q.size() > 0) chk(q[$] == SENT, req, "tail intact", q[$], SENT);
        @(negedge clk);
        q.delete();
        @(negedge clk);
    endtask

    initial begin
        dq_t o;
        int  idx, visited;
        rst = 1'b1; start = 1'b0; stall_en = 1'b0;
        req_avail = 1'b0; req_data = '0;
        checks = 0; errors = 0; cyc = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!req_pop && !rsp_push && !done && !error, "R1", "outputs in reset",
            {28'b0, req_pop, rsp_push, done, error}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(!req_pop && !rsp_push && !done && !error, "R1", "outputs after reset",
            {28'b0, req_pop, rsp_push, done, error}, 32'h0);

        // R2 R4: header parse, entry 0 reports discovery itself
        o = {32'h0000_0001, 32'h0000_0003, 32'h0};
        run(o, 1'b1, 32'h0100_0001, 1, "R4", 1'b0);

        // R5: walk the chain from 0 until next index 0
        idx = 0; visited = 0;
        do begin
            o = {32'h0000_0001, 32'h0000_0003, idx};
            run(o, 1'b1, exp_entry(idx), 1, "R5", 1'b0);
            visited++;
            idx = (idx + 1 < N) ? idx + 1 : 0;
        end while (idx != 0 && visited < 10);
        chk(visited == N, "R5", "entries visited", visited, N);

        // R6: upper bits of index dword ignored
        o = {32'h0000_0001, 32'h0000_0003, 32'hFFFF_FF02};
        run(o, 1'b1, exp_entry(2), 1, "R6", 1'b0);

        // R7: index at and beyond table size
        o = {32'h0000_0001, 32'h0000_0003, N};
        run(o, 1'b0, 32'h0, 1, "R7", 1'b0);
        o = {32'h0000_0001, 32'h0000_0003, 32'h0000_00FF};
        run(o, 1'b0, 32'h0, 1, "R7", 1'b0);

        // R8: short lengths stop after header dword 2
        o = {32'h0000_0001, 32'h0000_0002, 32'h0};
        run(o, 1'b0, 32'h0, 2, "R8", 1'b0);
        o = {32'h0000_0001, 32'h0000_0000, 32'h0};
        run(o, 1'b0, 32'h0, 2, "R8", 1'b0);

        // R9: foreign vendor, foreign type; object drained
        o = {32'h0000_1234, 32'h0000_0004, 32'h0, 32'h5};
        run(o, 1'b0, 32'h0, 1, "R9", 1'b0);
        o = {32'h0005_0001, 32'h0000_0003, 32'h0};
        run(o, 1'b0, 32'h0, 1, "R9", 1'b0);

        // R10 R2: longer object, length counts headers
        o = {32'h0000_0001, 32'h0000_0005, 32'h1, 32'hAAAA_AAAA, 32'h5555_5555};
        run(o, 1'b1, exp_entry(1), 1, "R10", 1'b0);

        // R11: stalled feed
        stall_en = 1'b1;
        o = {32'h0000_0001, 32'h0000_0004, 32'h3, 32'h1234_5678};
        run(o, 1'b1, exp_entry(3), 1, "R11", 1'b0);

        // R12 R13: second start while busy is ignored
        o = {32'h0000_0001, 32'h0000_0003, 32'h1};
        run(o, 1'b1, exp_entry(1), 1, "R12", 1'b1);
        stall_en = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule